// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a watchdog timer on a small single-cycle register bus. Software loads a 24-bit time-out constant. It sets an enable bit and then writes a two-byte key to a feed register. The key is 0xAA followed by 0x55. After that the block is armed, and a down-counter runs, stepping once for every four pulses of a watchdog clock enable.

Software must keep writing the key before the counter passes zero. If the counter underflows, the block raises either a latched interrupt flag or a sticky reset request, chosen by a mode bit. Once the block is armed, a feed sequence that is opened with 0xAA and then broken by any other register access is also treated as a fault. Before arming, broken sequences are simply dropped.

The watchdog clock is modelled as a one-cycle enable pulse in the bus clock domain. Reads return data combinationally from the addressed register.

Top module: `kwdog_top`

## Requirements
- R1: After reset, the mode register reads 0, the constant reads 0xFF, the counter reads 0xFF, and both `irq_o` and `rst_req_o` are low.
- R2: A write of a value below 0xFF to the constant register (address 1, bits [23:0]) stores 0xFF. Any other value is stored as written.
- R3: While armed, the counter drops by one on every fourth `wd_tick` pulse, counting pulses and not cycles. While not armed, it holds its value.
- R4: A write of 0xAA to the feed register (address 2, bits [7:0]) followed at the next bus access by a write of 0x55 reloads the counter from the constant and restarts the divide-by-four prescaler.
- R5: Setting the enable bit does not start counting. A completed feed while enable is 1 arms the block. A completed feed while enable is 0 reloads the counter but does not arm the block.
- R6: The enable bit can only be set by software. A write of 0 to it has no effect, and only reset clears it.
- R7: With reset-enable at 0, an underflow (a counter step taken while the counter is 0) sets the interrupt flag and `irq_o`. The counter then reloads from the constant.
- R8: With reset-enable at 1, an underflow sets `rst_req_o`, which stays high until reset, and leaves the interrupt flag clear.
- R9: While armed with 0xAA pending, any bus access other than a 0x55 feed write is a fault. The fault appears on `irq_o` or `rst_req_o` in the second clock after the bad access.
- R10: Before the block is armed, a broken feed sequence raises neither output.
- R11: Writing 1 to the flag bit of the mode register clears the interrupt flag and `irq_o`.
- R12: Register map by word address: 0 is mode, with bit 0 enable, bit 1 reset-enable and bit 2 flag. 1 is the constant. 2 is the feed register, which reads 0. 3 is the counter value, which is read-only so writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| wd_tick | input | 1 | Watchdog clock enable pulse |
| irq_o | output | 1 | Interrupt request, equal to the latched flag |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
The assertions assume that each bus access lasts exactly one cycle with `bus_sel` high. They also assume that `wd_tick` and the bus inputs change only between clock edges, and that reset-enable is not rewritten in the same cycle as a fault is recognised. The stimulus drives every input one time unit after a rising edge and holds it for whole cycles. It issues accesses one per cycle and touches the mode register only when no fault is in flight. Feed keys are always sent as back-to-back accesses, so the breaking access is the very next one.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;

  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_TC   = 2'd1,
    REG_FEED = 2'd2,
    REG_CNT  = 2'd3
  } reg_sel_e;

  localparam int MB_EN   = 0;
  localparam int MB_RSE  = 1;
  localparam int MB_FLAG = 2;

  localparam logic [7:0] KEY_OPEN  = 8'hAA;
  localparam logic [7:0] KEY_CLOSE = 8'h55;

  // Raise a requested time-out constant to the floor value.
  function automatic logic [31:0] clamp_tc(input logic [31:0] req, input logic [31:0] floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

  // One counter step: the value after a decrement.
  function automatic logic [31:0] step_down(input logic [31:0] cur);
    return cur - 32'd1;
  endfunction

endpackage

// File: rtl/kwdog_regs.sv
module kwdog_regs
  import kwdog_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CNT_W  = 24,
  parameter int TC_MIN = 'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             flag_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [DW-1:0]    rdata_o,
  output logic             en_o,
  output logic             rse_o,
  output logic             armed_o,
  output logic [CNT_W-1:0] tc_o,
  output logic             feed_ok_o,
  output logic             feed_bad_o,
  output logic             flag_clr_o
);

  localparam logic [CNT_W-1:0] TC_RST = CNT_W'(TC_MIN);

  logic             en_q, rse_q, armed_q, pend_q, pend_d;
  logic [CNT_W-1:0] tc_q;
  logic             mode_wr, tc_wr, feed_wr, seq_bad;
  logic [7:0]       key;
  logic [31:0]      tc_req;
  logic [DW-1:0]    wdata_unused;

  assign wdata_unused = bus_wdata;
  assign key     = bus_wdata[7:0];
  assign mode_wr = bus_sel && bus_wr && (bus_addr == REG_MODE);
  assign tc_wr   = bus_sel && bus_wr && (bus_addr == REG_TC);
  assign feed_wr = bus_sel && bus_wr && (bus_addr == REG_FEED);
  assign tc_req  = 32'(bus_wdata[CNT_W-1:0]);

  // Feed key sequencer: an open key makes the very next access decisive.
  always_comb begin
    pend_d    = pend_q;
    feed_ok_o = 1'b0;
    seq_bad   = 1'b0;
    if (bus_sel) begin
      if (pend_q) begin
        pend_d = 1'b0;
        if (feed_wr && key == KEY_CLOSE) feed_ok_o = 1'b1;
        else                             seq_bad   = 1'b1;
      end else if (feed_wr && key == KEY_OPEN) begin
        pend_d = 1'b1;
      end
    end
  end

  assign feed_bad_o = seq_bad && armed_q;
  assign flag_clr_o = mode_wr && bus_wdata[MB_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      rse_q   <= 1'b0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      tc_q    <= TC_RST;
    end else begin
      pend_q <= pend_d;
      if (mode_wr) begin
        en_q  <= en_q | bus_wdata[MB_EN];
        rse_q <= bus_wdata[MB_RSE];
      end
      if (tc_wr) tc_q <= CNT_W'(clamp_tc(tc_req, 32'(TC_MIN)));
      if (feed_ok_o && en_q) armed_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (bus_addr)
      REG_MODE: begin
        rdata_o[MB_EN]   = en_q;
        rdata_o[MB_RSE]  = rse_q;
        rdata_o[MB_FLAG] = flag_i;
      end
      REG_TC:  rdata_o = DW'(tc_q);
      REG_CNT: rdata_o = DW'(cnt_i);
      default: rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign rse_o   = rse_q;
  assign armed_o = armed_q;
  assign tc_o    = tc_q;

  a_r2_tc_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_wr && tc_req < 32'(TC_MIN)) |=> (tc_q == TC_RST));

  a_r6_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);

  a_r5_arm_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !armed_q) |=> !armed_q);

  a_r5_arm_on_feed: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_ok_o && en_q) |=> armed_q);

endmodule

// File: rtl/kwdog_counter.sv
module kwdog_counter
  import kwdog_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PRE_W  = 2,
  parameter int TC_MIN = 'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] tc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o
);

  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(TC_MIN);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dec_evt;

  // A counter step happens when the prescaler wraps.
  assign dec_evt = run_i && tick_i && (&pre_q);
  assign uf_o    = dec_evt && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= CNT_RST;
    end else if (reload_i) begin
      pre_q <= '0;
      cnt_q <= tc_i;
    end else begin
      if (run_i && tick_i) pre_q <= pre_q + 1'b1;
      if (uf_o)          cnt_q <= tc_i;
      else if (dec_evt)  cnt_q <= CNT_W'(step_down(32'(cnt_q)));
    end
  end

  assign cnt_o = cnt_q;

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !reload_i) |=> $stable(cnt_q));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_evt && !reload_i && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (cnt_q == $past(tc_i) && pre_q == '0));

  a_r7_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_o && !reload_i) |=> (cnt_q == $past(tc_i)));

endmodule

// File: rtl/kwdog_fault.sv
module kwdog_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic uf_i,
  input  logic bad_i,
  input  logic rse_i,
  input  logic clr_i,
  output logic flag_o,
  output logic rreq_o
);

  logic err_q, flag_q, rreq_q, fault_evt;

  // A bad feed is delayed one stage, so it lands in the second clock.
  assign fault_evt = uf_i || err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      flag_q <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      err_q <= bad_i;
      if (fault_evt && !rse_i) flag_q <= 1'b1;
      else if (clr_i)          flag_q <= 1'b0;
      if (fault_evt && rse_i)  rreq_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
  assign rreq_o = rreq_q;

  a_r8_request_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |=> rreq_q);

  a_r9_bad_feed_lands: assert property (@(posedge clk) disable iff (!rst_n)
    bad_i |-> ##2 (flag_q || rreq_q));

  a_r7_uf_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_i && !rse_i) |=> flag_q);

  a_r11_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !uf_i && !err_q) |=> !flag_q);

endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
  import kwdog_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CNT_W  = 24,
  parameter int PRE_W  = 2,
  parameter int TC_MIN = 'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          wd_tick,
  output logic          irq_o,
  output logic          rst_req_o
);

  logic             en, rse, armed, feed_ok, feed_bad, flag_clr, flag, uf;
  logic [CNT_W-1:0] tc, cnt;

  kwdog_regs #(.DW(DW), .CNT_W(CNT_W), .TC_MIN(TC_MIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flag_i(flag), .cnt_i(cnt),
    .rdata_o(bus_rdata), .en_o(en), .rse_o(rse), .armed_o(armed), .tc_o(tc),
    .feed_ok_o(feed_ok), .feed_bad_o(feed_bad), .flag_clr_o(flag_clr)
  );

  kwdog_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W), .TC_MIN(TC_MIN)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(armed), .tick_i(wd_tick),
    .reload_i(feed_ok), .tc_i(tc), .cnt_o(cnt), .uf_o(uf)
  );

  kwdog_fault u_fault (
    .clk(clk), .rst_n(rst_n), .uf_i(uf), .bad_i(feed_bad), .rse_i(rse),
    .clr_i(flag_clr), .flag_o(flag), .rreq_o(rst_req_o)
  );

  assign irq_o = flag;

  a_r10_quiet_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!irq_o && !rst_req_o));

  a_r5_armed_implies_enable: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> en);

endmodule

// File: tb/kwdog_top_tb_top.sv
module kwdog_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n, sel, wr, tick;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq, rreq;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  kwdog_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .wd_tick(tick),
    .irq_o(irq), .rst_req_o(rreq)
  );

  // Behavioural reference state
  bit m_en, m_rse, m_flag, m_rreq, m_armed, m_pend, m_errq;
  int m_pre, m_cnt, m_tc;

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {29'd0, m_flag, m_rse, m_en};
      2'd1: return m_tc;
      2'd3: return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_rse = 0; m_flag = 0; m_rreq = 0; m_armed = 0; m_pend = 0;
      m_errq = 0; m_pre = 0; m_cnt = 255; m_tc = 255;
    end else begin
      bit ok, bad, fw, step, wrap, fault, o_en, o_rse, o_armed, o_errq;
      int o_tc;
      o_en = m_en; o_rse = m_rse; o_armed = m_armed; o_errq = m_errq; o_tc = m_tc;
      ok = 0; bad = 0;
      fw = sel && wr && addr == 2'd2;
      if (sel) begin
        if (m_pend) begin
          m_pend = 0;
          if (fw && wdata[7:0] == 8'h55) ok = 1; else bad = 1;
        end else if (fw && wdata[7:0] == 8'hAA) m_pend = 1;
      end
      step  = o_armed && tick && m_pre == 3;
      wrap  = step && m_cnt == 0;
      fault = wrap || o_errq;
      if (fault && !o_rse) m_flag = 1;
      else if (sel && wr && addr == 2'd0 && wdata[2]) m_flag = 0;
      if (fault && o_rse) m_rreq = 1;
      m_errq = bad && o_armed;
      if (ok) begin m_cnt = o_tc; m_pre = 0; end
      else begin
        if (wrap) m_cnt = o_tc; else if (step) m_cnt = m_cnt - 1;
        if (o_armed && tick) m_pre = (m_pre + 1) % 4;
      end
      if (ok && o_en) m_armed = 1;
      if (sel && wr && addr == 2'd0) begin
        m_en = o_en || wdata[0];
        m_rse = wdata[1];
      end
      if (sel && wr && addr == 2'd1)
        m_tc = (wdata[23:0] < 24'hFF) ? 255 : int'(wdata[23:0]);
    end
  end

  task automatic check(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Clock-by-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      check(irq == m_flag, "R7/R11 irq", {31'd0, irq}, {31'd0, m_flag});
      check(rreq == m_rreq, "R8 rst_req", {31'd0, rreq}, {31'd0, m_rreq});
      check(rdata == m_read(addr), "R12 rdata", rdata, m_read(addr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic acc(input bit w, input logic [1:0] a, input logic [31:0] d);
    sel = 1'b1; wr = w; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    sel = 1'b1; wr = 1'b0; addr = a;
    #2 check(rdata == exp, tag, rdata, exp);
    @(posedge clk); #1;
    sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) begin @(posedge clk); #1; end
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic feed();
    acc(1, 2'd2, 32'hAA);
    acc(1, 2'd2, 32'h55);
  endtask

  initial begin
    rst_n = 1'b0; sel = 0; wr = 0; addr = 0; wdata = 0; tick = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(2'd0, 32'h0, "R1 mode");
    rd(2'd1, 32'hFF, "R1 constant");
    rd(2'd3, 32'hFF, "R1 counter");
    rd(2'd2, 32'h0, "R12 feed reads zero");
    check(!irq && !rreq, "R1 outputs", {30'd0, irq, rreq}, 32'd0);

    // R2 clamp, R12 read-only counter
    acc(1, 2'd1, 32'h10);
    rd(2'd1, 32'hFF, "R2 clamp");
    acc(1, 2'd1, 32'hFF00_0123);
    rd(2'd1, 32'h123, "R2 stored");
    acc(1, 2'd3, 32'h55);
    rd(2'd3, 32'hFF, "R12 counter write ignored");

    // R10 broken sequences before arming
    acc(1, 2'd2, 32'hAA);
    acc(0, 2'd1, 32'h0);
    acc(1, 2'd2, 32'hAA);
    acc(1, 2'd2, 32'h54);
    idle(3);
    check(!irq && !rreq, "R10 no fault unarmed", {30'd0, irq, rreq}, 32'd0);

    // R4/R5 feed without enable reloads only
    feed();
    rd(2'd3, 32'h123, "R4 reload");
    ticks(20);
    rd(2'd3, 32'h123, "R5 not armed without enable");

    // R5 enable alone, R6 set-only
    acc(1, 2'd0, 32'h1);
    ticks(8);
    rd(2'd3, 32'h123, "R5 enable alone");
    acc(1, 2'd0, 32'h0);
    rd(2'd0, 32'h1, "R6 enable stays");

    // R3 prescaled counting once armed
    feed();
    ticks(8);
    rd(2'd3, 32'h121, "R3 two steps");
    ticks(3);
    rd(2'd3, 32'h121, "R3 partial prescale");
    ticks(1);
    rd(2'd3, 32'h120, "R3 fourth pulse");
    for (int i = 0; i < 4; i++) begin ticks(1); idle(1); end
    rd(2'd3, 32'h11F, "R3 gapped pulses");

    // R4 prescaler restart on feed
    ticks(2);
    feed();
    ticks(3);
    rd(2'd3, 32'h123, "R4 prescaler restarted");
    ticks(1);
    rd(2'd3, 32'h122, "R4 first step after feed");

    // R7 underflow in interrupt mode
    acc(1, 2'd1, 32'h0);
    feed();
    ticks(1023);
    check(!irq, "R7 before underflow", {31'd0, irq}, 32'd0);
    rd(2'd3, 32'h0, "R7 counter at zero");
    ticks(1);
    check(irq, "R7 underflow irq", {31'd0, irq}, 32'd1);
    rd(2'd3, 32'hFF, "R7 reload after underflow");
    rd(2'd0, 32'h5, "R7 flag bit");

    // R11 write one to clear
    acc(1, 2'd0, 32'h4);
    rd(2'd0, 32'h1, "R11 flag cleared");
    check(!irq, "R11 irq low", {31'd0, irq}, 32'd0);

    // R9 feed error timing once armed
    acc(1, 2'd2, 32'hAA);
    sel = 1'b1; wr = 1'b0; addr = 2'd1;
    @(posedge clk); #1;
    sel = 1'b0;
    check(!irq, "R9 not in first clock", {31'd0, irq}, 32'd0);
    @(posedge clk); #1;
    check(irq, "R9 fault in second clock", {31'd0, irq}, 32'd1);
    acc(1, 2'd0, 32'h4);

    // R8 reset mode
    acc(1, 2'd0, 32'h3);
    feed();
    ticks(1024);
    check(rreq && !irq, "R8 reset request", {30'd0, irq, rreq}, 32'd1);
    idle(5);
    check(rreq, "R8 sticky", {31'd0, rreq}, 32'd1);

    // R1/R6 reset clears everything
    rst_n = 1'b0;
    #2;
    check(!irq && !rreq, "R1 outputs after reset", {30'd0, irq, rreq}, 32'd0);
    addr = 2'd0;
    #1 check(rdata == 32'h0, "R6 enable cleared by reset", rdata, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule